// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a set of external interrupt pins and raises a single interrupt request toward a CPU. Each pin is first brought into the clock domain by a two-stage synchronizer. Each line then senses either a level or an edge, with a polarity the CPU chooses per line. A sensed event sets a per-line status bit. A per-line enable mask decides which status bits may reach the combined request output.

The CPU reaches the block through a plain synchronous register port. A write is taken on any clock edge where the write strobe is high. A read returns data on `rdata_o` one clock after the address is presented. The mask is changed only through separate set and clear strobe registers, so no read-modify-write is needed. Status bits of edge-sensed lines are cleared by writing ones to an acknowledge register. The sense configuration registers implement only as many bits as there are lines, so software can count the lines by writing all ones and reading the value back.

The port carries register traffic only, with no streaming data. It therefore has no valid/ready handshake and no back-pressure: every access completes in one cycle.

Top module: `extirq_ctrl`

## Requirements
- R1: A write to address 0 (mask set) sets every mask bit whose write-data bit is 1 and leaves bits written 0 unchanged. The mask reads back at address 3, where bit i is line i.
- R2: A write to address 1 (mask clear) clears every mask bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R3: A write to address 2 (acknowledge) clears the status bit of each edge-sensed line written 1. Lines written 0 keep their status. Status reads back at address 4.
- R4: The sense register at address 5 selects level sensing for a line when its bit is 1 and edge sensing when its bit is 0.
- R5: In edge mode, a 1 in the edge polarity register (address 6) detects rising edges and a 0 detects falling edges. An edge of the other direction leaves status unchanged. An edge-mode status bit stays set until it is acknowledged.
- R6: In level mode, a 1 in the level polarity register (address 7) makes the line active-high and a 0 makes it active-low. Status follows the active level, and an acknowledge has no effect while the line is still active.
- R7: `irq_o` is high exactly when some line has both its status bit and its mask bit set.
- R8: Bits of the sense register above the implemented line count read back as 0. Writing all ones to address 5 and reading it back yields 2^N-1.
- R9: After reset, mask and status read 0 and `irq_o` is low. The sense and edge polarity registers read 0, which gives falling-edge detection on every line.
- R10: When an acknowledge write and a new detected edge hit the same line in the same cycle, the status bit stays set.
- R11: A pin change reaches status and `irq_o` on the third rising clock edge after it is applied, and not earlier. Register reads return data one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | N | External interrupt pins, asynchronous |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, registered |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the very cycle a fresh edge is recognised. The bench reaches it by counting the synchronizer delay. It drives the pin transition, lets two rising clock edges pass, and places the acknowledge write so that it is sampled on the same edge that latches the detected event. The same counting pins down the three-edge latency: the bench watches `irq_o` with the line unmasked, before and after the third edge.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] RA_MSK_SET = 4'd0;
  localparam logic [ADDR_W-1:0] RA_MSK_CLR = 4'd1;
  localparam logic [ADDR_W-1:0] RA_ACK     = 4'd2;
  localparam logic [ADDR_W-1:0] RA_MSK     = 4'd3;
  localparam logic [ADDR_W-1:0] RA_STS     = 4'd4;
  localparam logic [ADDR_W-1:0] RA_SENSE   = 4'd5;
  localparam logic [ADDR_W-1:0] RA_EPOL    = 4'd6;
  localparam logic [ADDR_W-1:0] RA_LPOL    = 4'd7;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_line.sv
module extirq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic lvl_mode_i,
  input  logic rise_sel_i,
  input  logic high_sel_i,
  input  logic ack_i,
  output logic sts_o
);
  logic prev_q;
  logic sts_q;
  logic edge_hit;
  logic active;

  assign edge_hit = rise_sel_i ? (pin_s_i & ~prev_q) : (~pin_s_i & prev_q);
  assign active   = high_sel_i ? pin_s_i : ~pin_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      if (lvl_mode_i) sts_q <= active;
      else            sts_q <= edge_hit | (sts_q & ~ack_i);
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N-1:0]      sts_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      epol_o,
  output logic [N-1:0]      lpol_o,
  output logic [N-1:0]      ack_o,
  output logic [DW-1:0]     rdata_o
);
  logic [N-1:0]  mask_q, sense_q, epol_q, lpol_q;
  logic [N-1:0]  wbits;
  logic [DW-1:0] rd_d, rd_q;

  assign wbits = wdata_i[N-1:0];
  assign ack_o = (wr_en_i && addr_i == RA_ACK) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sense_q <= '0;
      epol_q  <= '0;
      lpol_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_MSK_SET: mask_q  <= mask_q | wbits;
        RA_MSK_CLR: mask_q  <= mask_q & ~wbits;
        RA_SENSE:   sense_q <= wbits;
        RA_EPOL:    epol_q  <= wbits;
        RA_LPOL:    lpol_q  <= wbits;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      RA_MSK:   rd_d = DW'(mask_q);
      RA_STS:   rd_d = DW'(sts_i);
      RA_SENSE: rd_d = DW'(sense_q);
      RA_EPOL:  rd_d = DW'(epol_q);
      RA_LPOL:  rd_d = DW'(lpol_q);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign mask_o  = mask_q;
  assign sense_o = sense_q;
  assign epol_o  = epol_q;
  assign lpol_o  = lpol_q;
  assign rdata_o = rd_q;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic [N-1:0] pins_s;
  logic [N-1:0] mask_q, sense_q, epol_q, lpol_q, ack_w, status_w;

  extirq_sync #(.W(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_s)
  );

  extirq_regs #(.N(N), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .sts_i(status_w), .mask_o(mask_q),
    .sense_o(sense_q), .epol_o(epol_q), .lpol_o(lpol_q),
    .ack_o(ack_w), .rdata_o(rdata_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    extirq_line u_line (
      .clk(clk), .rst_n(rst_n), .pin_s_i(pins_s[i]),
      .lvl_mode_i(sense_q[i]), .rise_sel_i(epol_q[i]),
      .high_sel_i(lpol_q[i]), .ack_i(ack_w[i]), .sts_o(status_w[i])
    );
  end

  assign irq_o = |(status_w & mask_q);
endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk
  import extirq_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              irq_o,
  input logic [N-1:0]      msk,
  input logic [N-1:0]      sts,
  input logic [N-1:0]      mode,
  input logic [N-1:0]      clr
);
  logic [N-1:0] wb;
  logic [N-1:0] keep;
  assign wb   = wdata_i[N-1:0];
  assign keep = sts & ~clr & ~mode;

  a_r1_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == RA_MSK_SET) |=> ((msk & $past(wb)) == $past(wb)));

  a_r2_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == RA_MSK_CLR) |=> ((msk & $past(wb)) == '0));

  a_r1_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (addr_i == RA_MSK_SET || addr_i == RA_MSK_CLR)) |=> $stable(msk));

  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(keep)) == $past(keep)));

  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sts & msk) == 0) |-> !irq_o);

  a_r8_sense_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == RA_SENSE) |=> ((rdata_o >> N) == '0));
endmodule

bind extirq_ctrl extirq_ctrl_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .msk(mask_q), .sts(status_w), .mode(sense_q), .clr(ack_w)
);

// File: tb/tb_extirq_ctrl.sv
`timescale 1ns/1ps
module tb_extirq_ctrl;
  localparam int N  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic [3:0]    addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  extirq_ctrl #(.N(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr),
    .wr_en_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9 irq", {31'b0, irq}, 32'h0);
    rd(4'd3, v); check("R9 mask", v, 32'h0);
    rd(4'd4, v); check("R9 status", v, 32'h0);
    rd(4'd5, v); check("R9 sense", v, 32'h0);
    rd(4'd6, v); check("R9 edge pol", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(4'd0, 32'h0F); rd(4'd3, v); check("R1 set", v, 32'h0F);
    wr(4'd0, 32'h30); rd(4'd3, v); check("R1 zero bits keep", v, 32'h3F);
    wr(4'd1, 32'h05); rd(4'd3, v); check("R2 clear", v, 32'h3A);
  endtask

  task automatic t_fall_default();
    logic [31:0] v;
    pins[0] = 1'b1; settle();
    rd(4'd4, v); check("R9 rising ignored by default", v, 32'h0);
    pins[0] = 1'b0; settle();
    rd(4'd4, v); check("R5 falling sets status", v, 32'h01);
    check("R7 masked line no irq", {31'b0, irq}, 32'h0);
    wr(4'd0, 32'h01);
    check("R7 unmasked irq", {31'b0, irq}, 32'h1);
    wr(4'd2, 32'h02); rd(4'd4, v); check("R3 zero bit no ack", v, 32'h01);
    check("R5 sticky irq", {31'b0, irq}, 32'h1);
    wr(4'd2, 32'h01); rd(4'd4, v); check("R3 ack clears", v, 32'h0);
    check("R7 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(4'd6, 32'h02);
    pins[1] = 1'b1; settle();
    rd(4'd4, v); check("R5 rising sets", v, 32'h02);
    wr(4'd2, 32'h02);
    pins[1] = 1'b0; settle();
    rd(4'd4, v); check("R5 falling ignored when rising", v, 32'h0);
    wr(4'd6, 32'h0);
    wr(4'd2, 32'hFF);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(4'd7, 32'h04);
    wr(4'd5, 32'h04);
    rd(4'd4, v); check("R4 level inactive", v, 32'h0);
    pins[2] = 1'b1; settle();
    rd(4'd4, v); check("R6 active high", v, 32'h04);
    wr(4'd2, 32'h04); rd(4'd4, v); check("R6 ack ignored while active", v, 32'h04);
    pins[2] = 1'b0; settle();
    rd(4'd4, v); check("R6 follows inactive", v, 32'h0);
    wr(4'd7, 32'h00); @(negedge clk);
    rd(4'd4, v); check("R6 active low", v, 32'h04);
    wr(4'd5, 32'h00);
    wr(4'd2, 32'h04);
    rd(4'd4, v); check("R4 back to edge, acked", v, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    pins[3] = 1'b1; settle();
    pins[3] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(4'd2, 32'h08);
    rd(4'd4, v); check("R10 edge beats ack", v, 32'h08);
    wr(4'd2, 32'h08);
    rd(4'd4, v); check("R10 later ack clears", v, 32'h0);
  endtask

  task automatic t_latency();
    wr(4'd0, 32'h10);
    pins[4] = 1'b1; settle();
    pins[4] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 not before third edge", {31'b0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 at third edge", {31'b0, irq}, 32'h1);
    wr(4'd2, 32'h10);
    wr(4'd1, 32'hFF);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, v); check("R8 implemented lines", v, 32'h0000_00FF);
    wr(4'd5, 32'h0);
    rd(4'd5, v); check("R4 sense restored", v, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_fall_default();
    t_rise();
    t_level();
    t_collision();
    t_latency();
    t_count();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule